// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division, signed or unsigned, one step per clock. A single adder/subtractor and one shift path serve every operation. A multiply uses shift-and-add, with one partial-product addition per cycle. A divide uses the restoring method, with one trial subtraction per cycle. Signed operations run on operand magnitudes, and the signs are corrected in one final cycle.

The unit has two result registers. `hi` holds the upper product word, or the remainder after a divide. `lo` holds the lower product word, or the quotient after a divide. The surrounding pipeline reads both registers directly. To launch an operation, pulse `start` with an operation code and two operands. `busy` stays high for the whole operation. `done` pulses for one cycle when the results are valid. The unit checks nothing for overflow and does not flag division by zero; a zero divisor gives a fixed, predictable result.

Top module: `muldiv_iter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy` and `done` are low, and `hi` and `lo` read zero.
- R2: Operation code 2'b01 (unsigned multiply) leaves the upper 32 bits of the 64-bit unsigned product in `hi` and the lower 32 bits in `lo`.
- R3: Operation code 2'b00 (signed multiply) leaves the 64-bit two's-complement product of the two signed operands in `hi` (upper word) and `lo` (lower word).
- R4: Operation code 2'b11 (unsigned divide) with a nonzero divisor leaves the quotient `opa / opb` in `lo` and the remainder in `hi`.
- R5: Operation code 2'b10 (signed divide) with a nonzero divisor truncates the quotient toward zero. The quotient is negative exactly when the operand signs differ, and the remainder takes the sign of the dividend. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: A zero divisor gives a quotient magnitude of all ones and a remainder magnitude equal to the dividend magnitude, and both are then sign-corrected as in R5. An unsigned divide gives `lo`=0xFFFFFFFF and `hi`=`opa`. A signed divide gives `hi`=`opa`, and `lo`=1 for a negative dividend or 0xFFFFFFFF otherwise.
- R7: When `start` is sampled high while idle, `busy` is high from the next cycle on. `done` rises for exactly one cycle 33 clock edges after the accepting edge, and `busy` is low in that same cycle.
- R8: A `start` pulse while `busy` is high is ignored: the operation in progress finishes on time with its own operands.
- R9: A `start` pulse in the cycle where `done` is high is accepted, so operations can run back to back.
- R10: While the unit is idle and `start` is low, `hi` and `lo` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation when idle |
| op | input | 2 | Operation: bit 1 selects divide, bit 0 selects unsigned |
| opa | input | 32 | Multiplicand, or dividend |
| opb | input | 32 | Multiplier, or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| hi | output | 32 | Upper product word, or remainder |
| lo | output | 32 | Lower product word, or quotient |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle. The bench raises `start` with new operands in exactly the cycle where `done` is high. In that cycle it checks that the first operation's results are visible. It then checks that `busy` rises on the next cycle and that the second result arrives on schedule and is correct. A second collision, a `start` arriving while busy, is provoked in the middle of an operation. It is judged by the unchanged completion time and the first operation's result.

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  mcand;
  logic          is_div, neg_lo, neg_hi;

  wire accept = start && (st == S_IDLE);
  wire sgn    = ~op[0];
  wire a_neg  = sgn & opa[W-1];
  wire b_neg  = sgn & opb[W-1];
  wire [W-1:0] a_mag = a_neg ? -opa : opa;
  wire [W-1:0] b_mag = b_neg ? -opb : opb;

  wire [W:0] add_a  = is_div ? {hi, lo[W-1]} : {1'b0, hi};
  wire [W:0] add_b  = is_div ? ~{1'b0, mcand} : {1'b0, mcand};
  wire       add_en = is_div | lo[0];
  wire [W:0] sum    = add_a + (add_en ? add_b : '0) + {{W{1'b0}}, is_div};
  wire       q_bit  = ~sum[W];

  wire [2*W-1:0] prod_neg = -{hi, lo};

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      mcand  <= '0;
      is_div <= 1'b0;
      neg_lo <= 1'b0;
      neg_hi <= 1'b0;
      hi     <= '0;
      lo     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_RUN;
          cnt    <= '0;
          mcand  <= b_mag;
          is_div <= op[1];
          neg_lo <= a_neg ^ b_neg;
          neg_hi <= op[1] & a_neg;
          hi     <= '0;
          lo     <= a_mag;
        end
        S_RUN: begin
          if (is_div) begin
            hi <= q_bit ? sum[W-1:0] : add_a[W-1:0];
            lo <= {lo[W-2:0], q_bit};
          end else begin
            hi <= sum[W:1];
            lo <= {sum[0], lo[W-1:1]};
          end
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FIX;
        end
        S_FIX: begin
          if (is_div) begin
            if (neg_lo) lo <= -lo;
            if (neg_hi) hi <= -hi;
          end else if (neg_lo) begin
            {hi, lo} <= prod_neg;
          end
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi) && $stable(lo))); // R10
  AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(is_div) && $stable(mcand))); // R8
  AST_COUNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIX) |-> (cnt == '0 || cnt == CW'(W))); // R7
endmodule

// File: tb/muldiv_iter_tb.sv
module muldiv_iter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [31:0] opa, opb;
  logic        busy, done;
  logic [31:0] hi, lo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  muldiv_iter #(.W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  localparam int NV = 18;
  localparam logic [65:0] VEC [NV] = '{
    {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {2'b01, 32'h12345678, 32'h9ABCDEF0},
    {2'b01, 32'h00000000, 32'hDEADBEEF},
    {2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {2'b00, 32'hFFFFFFFB, 32'h00000007},
    {2'b00, 32'h80000000, 32'h80000000},
    {2'b00, 32'h80000000, 32'h00000001},
    {2'b11, 32'd100,      32'd7},
    {2'b11, 32'hFFFFFFFF, 32'h00000001},
    {2'b11, 32'd5,        32'd9},
    {2'b10, 32'hFFFFFFF9, 32'd2},
    {2'b10, 32'd7,        32'hFFFFFFFE},
    {2'b10, 32'hFFFFFFF9, 32'hFFFFFFFE},
    {2'b10, 32'h80000000, 32'hFFFFFFFF},
    {2'b11, 32'd12345,    32'd0},
    {2'b10, 32'hFFFFFFF9, 32'd0},
    {2'b10, 32'd7,        32'd0},
    {2'b11, 32'h80000001, 32'h00010000}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] o, input logic [31:0] b);
    if (o[1] && b == 0) return "R6";
    case (o)
      2'b00: return "R3";
      2'b01: return "R2";
      2'b10: return "R5";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [1:0] o,
                                        input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, q, r;
    sa = o[0] ? $signed({32'b0, a}) : $signed({{32{a[31]}}, a});
    sb = o[0] ? $signed({32'b0, b}) : $signed({{32{b[31]}}, b});
    if (!o[1]) return 64'(sa * sb);
    if (b == 0) begin
      if (o[0]) return {a, 32'hFFFFFFFF};
      return {a, (a[31] ? 32'h1 : 32'hFFFFFFFF)};
    end
    q = sa / sb;
    r = sa % sb;
    return {r[31:0], q[31:0]};
  endfunction

  // Called at a negedge; returns at the negedge after done rises.
  task automatic run_op(input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] b, input bit timing);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; opa = ~a; opb = ~b;
    if (timing) chk("R7", "busy after accept", {31'b0, busy}, 32'd1);
    repeat (32) @(negedge clk);
    if (timing) chk("R7", "done early", {31'b0, done}, 32'd0);
    @(negedge clk);
    if (timing) begin
      chk("R7", "done pulse", {31'b0, done}, 32'd1);
      chk("R7", "busy low at done", {31'b0, busy}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] e;
    rst_n = 1'b0; start = 1'b0; op = 2'b00; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'b0, busy}, 32'd0);
    chk("R1", "done in reset", {31'b0, done}, 32'd0);
    chk("R1", "hi in reset", hi, 32'd0);
    chk("R1", "lo in reset", lo, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "hi after reset", hi, 32'd0);
    chk("R1", "busy after reset", {31'b0, busy}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      e = model(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
      run_op(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0], i < 3);
      chk(req_of(VEC[i][65:64], VEC[i][31:0]), "hi", hi, e[63:32]);
      chk(req_of(VEC[i][65:64], VEC[i][31:0]), "lo", lo, e[31:0]);
      @(negedge clk);
    end

    // R10: results hold while idle
    e = {hi, lo};
    repeat (6) @(negedge clk);
    chk("R10", "hi held", hi, e[63:32]);
    chk("R10", "lo held", lo, e[31:0]);
    chk("R10", "no stray done", {31'b0, done}, 32'd0);

    // R8: start mid-operation is ignored
    start = 1'b1; op = 2'b01; opa = 32'd1000; opb = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'b11; opa = 32'd77; opb = 32'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (26) @(negedge clk);
    chk("R8", "done not yet", {31'b0, done}, 32'd0);
    @(negedge clk);
    chk("R8", "done on schedule", {31'b0, done}, 32'd1);
    chk("R8", "hi of first op", hi, 32'd0);
    chk("R8", "lo of first op", lo, 32'd3000);
    @(negedge clk);
    chk("R8", "second start dropped", {31'b0, busy}, 32'd0);

    // R9: start in the done cycle
    run_op(2'b00, 32'hFFFFFFFD, 32'd4, 1'b0);
    chk("R9", "first lo at done", lo, 32'hFFFFFFF4);
    chk("R9", "first hi at done", hi, 32'hFFFFFFFF);
    run_op(2'b10, 32'hFFFFFF9C, 32'd7, 1'b1);
    chk("R9", "second quotient", lo, 32'hFFFFFFF2);
    chk("R9", "second remainder", hi, 32'hFFFFFFFE);

    // R1: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; op = 2'b01; opa = 32'd9; opb = 32'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "busy cleared", {31'b0, busy}, 32'd0);
    chk("R1", "lo cleared", lo, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule